// File: doc/BRIEF.md
# Ternary Full Adder Word

This block adds two words of three-valued digits (trits) plus a carry-in trit. The addition uses explicit ternary gates rather than an arithmetic operator. Each trit travels on a two-bit code. A single parameter sets how every digit is read: unsigned (0, 1, 2) or balanced (-1, 0, +1). Balanced words are signed and carry no separate sign digit.

Every digit position is one full adder, built in three steps:

- A first half adder combines the two operand trits. Each half adder is one digit-sum gate and one inverted-carry gate.
- A second half adder adds that partial sum to the incoming carry.
- A combining gate merges the two inverted carries into the carry-out trit.

The digit positions ripple from the least significant trit upwards. The sum word, the carry-out trit and an illegal-code flag are captured in one output register stage, which has a synchronous active-high reset.

Codes: unsigned 2'b00=0, 2'b01=1, 2'b10=2. Balanced 2'b10=-1, 2'b00=0, 2'b01=+1. Code 2'b11 is never a legal trit.

Top module: `tern_ripple_adder`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `sum_word` all 2'b00, `carry_out` 2'b00 and `code_err` 0.
- R2: Outputs appear exactly one rising edge after the inputs are sampled, and they hold their value until the next edge.
- R3: With BALANCED=0 and legal codes, the trit at the least significant position satisfies a+b+cin = 3·carry + sum for every one of the 27 digit combinations (digits 0..2; 2'b00=0, 2'b01=1, 2'b10=2).
- R4: With BALANCED=1 and legal codes, the same identity holds for all 27 combinations of digits in {-1,0,+1} (2'b10=-1, 2'b00=0, 2'b01=+1), and every result digit is in {-1,0,+1}.
- R5: The carry ripples through every trit. The word value A+B+carry_in equals sum_word + 3^NTRITS·carry_out, with the lowest trit in bits [1:0].
- R6: `code_err` is 1 in the result cycle of any sample where a trit of `a_word`, `b_word` or `carry_in` is 2'b11, and 0 otherwise.
- R7: Whatever the inputs, no trit of `sum_word` and never `carry_out` takes the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_word | input | 2*NTRITS | First operand, trit i in bits [2i+1:2i] |
| b_word | input | 2*NTRITS | Second operand, same layout |
| carry_in | input | 2 | Carry trit into the lowest position |
| sum_word | output | 2*NTRITS | Registered sum trits |
| carry_out | output | 2 | Registered carry trit out of the top position |
| code_err | output | 1 | Registered flag: an input carried code 2'b11 |

## Verification
An illegal code in one trit and a carry rippling through its neighbours can fall in the same cycle. The bench provokes this in both digit modes. It fills the low trits with their largest value so that a carry is produced. It places 2'b11 in the trit that carry must enter, or on `carry_in` itself. The sample is judged correct when `code_err` is raised and, at the same time, no output trit or carry shows 2'b11. The next legal sample must clear the flag and again produce the exact word sum.

// File: rtl/tern_pkg.sv
package tern_pkg;

    typedef logic [1:0] trit_t;

    // shared code points; zero is 2'b00 in both digit modes
    localparam trit_t TC_ZERO = 2'b00;
    localparam trit_t TC_ONE  = 2'b01;
    localparam trit_t TC_TWO  = 2'b10;
    localparam trit_t TC_POS  = 2'b01;
    localparam trit_t TC_NEG  = 2'b10;
    localparam trit_t TC_BAD  = 2'b11;

    typedef struct packed {
        trit_t digit;
        trit_t ncarry;
    } half_res_t;

    // numeric value of a code, for checks only
    function automatic int trit_value(trit_t c, bit balanced);
        case (c)
            2'b00:   return 0;
            2'b01:   return 1;
            2'b10:   return balanced ? -1 : 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic trit_bad(trit_t c);
        return c == TC_BAD;
    endfunction

endpackage

// File: rtl/tern_sum_gate.sv
module tern_sum_gate
    import tern_pkg::*;
#(
    parameter bit BALANCED = 1'b0
) (
    input  trit_t x,
    input  trit_t y,
    output trit_t z
);
    generate
        if (BALANCED) begin : g_bal
            always_comb begin
                case ({x, y})
                    {TC_NEG, TC_NEG}:  z = TC_POS;
                    {TC_NEG, TC_ZERO}: z = TC_NEG;
                    {TC_NEG, TC_POS}:  z = TC_ZERO;
                    {TC_ZERO, TC_NEG}: z = TC_NEG;
                    {TC_ZERO, TC_ZERO}: z = TC_ZERO;
                    {TC_ZERO, TC_POS}: z = TC_POS;
                    {TC_POS, TC_NEG}:  z = TC_ZERO;
                    {TC_POS, TC_ZERO}: z = TC_POS;
                    {TC_POS, TC_POS}:  z = TC_NEG;
                    default:           z = TC_ZERO;
                endcase
            end
        end else begin : g_uns
            always_comb begin
                case ({x, y})
                    {TC_ZERO, TC_ZERO}: z = TC_ZERO;
                    {TC_ZERO, TC_ONE}:  z = TC_ONE;
                    {TC_ZERO, TC_TWO}:  z = TC_TWO;
                    {TC_ONE, TC_ZERO}:  z = TC_ONE;
                    {TC_ONE, TC_ONE}:   z = TC_TWO;
                    {TC_ONE, TC_TWO}:   z = TC_ZERO;
                    {TC_TWO, TC_ZERO}:  z = TC_TWO;
                    {TC_TWO, TC_ONE}:   z = TC_ZERO;
                    {TC_TWO, TC_TWO}:   z = TC_ONE;
                    default:            z = TC_ZERO;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/tern_ncarry_gate.sv
module tern_ncarry_gate
    import tern_pkg::*;
#(
    parameter bit BALANCED = 1'b0
) (
    input  trit_t x,
    input  trit_t y,
    output trit_t z
);
    generate
        if (BALANCED) begin : g_bal
            // negated carry of a signed digit pair
            always_comb begin
                case ({x, y})
                    {TC_NEG, TC_NEG}:   z = TC_POS;
                    {TC_POS, TC_POS}:   z = TC_NEG;
                    default:            z = TC_ZERO;
                endcase
            end
        end else begin : g_uns
            // inverted carry: 2 means none, 1 means one carried
            always_comb begin
                case ({x, y})
                    {TC_ONE, TC_TWO},
                    {TC_TWO, TC_ONE},
                    {TC_TWO, TC_TWO}:   z = TC_ONE;
                    {TC_ZERO, TC_ZERO},
                    {TC_ZERO, TC_ONE},
                    {TC_ZERO, TC_TWO},
                    {TC_ONE, TC_ZERO},
                    {TC_ONE, TC_ONE},
                    {TC_TWO, TC_ZERO}:  z = TC_TWO;
                    default:            z = TC_ZERO;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/tern_nany_gate.sv
module tern_nany_gate
    import tern_pkg::*;
#(
    parameter bit BALANCED = 1'b0
) (
    input  trit_t x,
    input  trit_t y,
    output trit_t z
);
    generate
        if (BALANCED) begin : g_bal
            // negated, saturated sum of two inverted carries
            always_comb begin
                case ({x, y})
                    {TC_NEG, TC_NEG},
                    {TC_NEG, TC_ZERO},
                    {TC_ZERO, TC_NEG}:  z = TC_POS;
                    {TC_ZERO, TC_POS},
                    {TC_POS, TC_ZERO},
                    {TC_POS, TC_POS}:   z = TC_NEG;
                    default:            z = TC_ZERO;
                endcase
            end
        end else begin : g_uns
            always_comb begin
                case ({x, y})
                    {TC_TWO, TC_TWO}:   z = TC_ZERO;
                    {TC_ZERO, TC_TWO},
                    {TC_ONE, TC_TWO},
                    {TC_TWO, TC_ZERO},
                    {TC_TWO, TC_ONE}:   z = TC_ONE;
                    {TC_ZERO, TC_ZERO},
                    {TC_ZERO, TC_ONE},
                    {TC_ONE, TC_ZERO},
                    {TC_ONE, TC_ONE}:   z = TC_TWO;
                    default:            z = TC_ZERO;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/tern_half_adder.sv
module tern_half_adder
    import tern_pkg::*;
#(
    parameter bit BALANCED = 1'b0
) (
    input  trit_t     x,
    input  trit_t     y,
    output half_res_t res
);
    tern_sum_gate #(.BALANCED(BALANCED)) u_sum (
        .x (x),
        .y (y),
        .z (res.digit)
    );

    tern_ncarry_gate #(.BALANCED(BALANCED)) u_ncarry (
        .x (x),
        .y (y),
        .z (res.ncarry)
    );
endmodule

// File: rtl/tern_full_adder.sv
module tern_full_adder
    import tern_pkg::*;
#(
    parameter bit BALANCED = 1'b0
) (
    input  trit_t a,
    input  trit_t b,
    input  trit_t cin,
    output trit_t sum,
    output trit_t cout
);
    half_res_t first_ha;
    half_res_t second_ha;

    tern_half_adder #(.BALANCED(BALANCED)) u_ha_ops (
        .x   (a),
        .y   (b),
        .res (first_ha)
    );

    tern_half_adder #(.BALANCED(BALANCED)) u_ha_cin (
        .x   (first_ha.digit),
        .y   (cin),
        .res (second_ha)
    );

    tern_nany_gate #(.BALANCED(BALANCED)) u_merge (
        .x (first_ha.ncarry),
        .y (second_ha.ncarry),
        .z (cout)
    );

    assign sum = second_ha.digit;
endmodule

// File: rtl/tern_ripple_adder.sv
module tern_ripple_adder
    import tern_pkg::*;
#(
    parameter int NTRITS   = 4,
    parameter bit BALANCED = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2*NTRITS-1:0] a_word,
    input  logic [2*NTRITS-1:0] b_word,
    input  logic [1:0]          carry_in,
    output logic [2*NTRITS-1:0] sum_word,
    output logic [1:0]          carry_out,
    output logic                code_err
);
    localparam int WORD_W  = 2 * NTRITS;
    localparam int CHAIN_W = 2 * (NTRITS + 1);

    logic [CHAIN_W-1:0] carry_chain;
    logic [WORD_W-1:0]  sum_comb;
    logic [NTRITS-1:0]  bad_a;
    logic [NTRITS-1:0]  bad_b;
    logic               bad_any;

    assign carry_chain[1:0] = carry_in;

    generate
        for (genvar g = 0; g < NTRITS; g++) begin : g_pos
            tern_full_adder #(.BALANCED(BALANCED)) u_fa (
                .a    (a_word[2*g +: 2]),
                .b    (b_word[2*g +: 2]),
                .cin  (carry_chain[2*g +: 2]),
                .sum  (sum_comb[2*g +: 2]),
                .cout (carry_chain[2*g+2 +: 2])
            );
            assign bad_a[g] = trit_bad(a_word[2*g +: 2]);
            assign bad_b[g] = trit_bad(b_word[2*g +: 2]);

            AST_NO_BAD_SUM: assert property (@(posedge clk) disable iff (rst)
                sum_word[2*g +: 2] != TC_BAD); // R7

            if (BALANCED) begin : g_chk_bal
                AST_DIGIT_IDENTITY_BAL: assert property (@(posedge clk) disable iff (rst)
                    !bad_any |->
                    (trit_value(a_word[2*g +: 2], 1'b1) + trit_value(b_word[2*g +: 2], 1'b1)
                     + trit_value(carry_chain[2*g +: 2], 1'b1)
                     == 3 * trit_value(carry_chain[2*g+2 +: 2], 1'b1)
                        + trit_value(sum_comb[2*g +: 2], 1'b1))); // R4
            end else begin : g_chk_uns
                AST_DIGIT_IDENTITY_UNS: assert property (@(posedge clk) disable iff (rst)
                    !bad_any |->
                    (trit_value(a_word[2*g +: 2], 1'b0) + trit_value(b_word[2*g +: 2], 1'b0)
                     + trit_value(carry_chain[2*g +: 2], 1'b0)
                     == 3 * trit_value(carry_chain[2*g+2 +: 2], 1'b0)
                        + trit_value(sum_comb[2*g +: 2], 1'b0))); // R3
            end
        end
    endgenerate

    assign bad_any = (|bad_a) | (|bad_b) | trit_bad(carry_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_word  <= '0;
            carry_out <= TC_ZERO;
            code_err  <= 1'b0;
        end else begin
            sum_word  <= sum_comb;
            carry_out <= carry_chain[CHAIN_W-1 -: 2];
            code_err  <= bad_any;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (sum_word == '0 && carry_out == TC_ZERO && !code_err)); // R1

    AST_NO_BAD_CARRY: assert property (@(posedge clk) disable iff (rst)
        carry_out != TC_BAD); // R7

    AST_ERR_RAISED: assert property (@(posedge clk) disable iff (rst)
        trit_bad(carry_in) |=> code_err); // R6

endmodule

// File: tb/tern_ripple_adder_test.sv
`timescale 1ns/1ps
module tern_ripple_adder_test;
    localparam int NT   = 4;
    localparam int W    = 2 * NT;
    localparam int SPAN = 81; // 3**NT

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_u = '0, b_u = '0, a_b = '0, b_b = '0;
    logic [1:0]   c_u = '0, c_b = '0;
    logic [W-1:0] s_u, s_b;
    logic [1:0]   co_u, co_b;
    logic         e_u, e_b;
    int           n_checks = 0;
    int           n_fails  = 0;

    always #5 clk = ~clk;

    tern_ripple_adder #(.NTRITS(NT), .BALANCED(1'b0)) uut (
        .clk(clk), .rst(rst), .a_word(a_u), .b_word(b_u), .carry_in(c_u),
        .sum_word(s_u), .carry_out(co_u), .code_err(e_u));

    tern_ripple_adder #(.NTRITS(NT), .BALANCED(1'b1)) uut_bal (
        .clk(clk), .rst(rst), .a_word(a_b), .b_word(b_b), .carry_in(c_b),
        .sum_word(s_b), .carry_out(co_b), .code_err(e_b));

    function automatic logic [1:0] code_u(int d);
        return (d == 0) ? 2'b00 : (d == 1) ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [1:0] code_b(int d);
        return (d == 0) ? 2'b00 : (d == 1) ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [W-1:0] word_u(int v);
        logic [W-1:0] w = '0;
        int r = v;
        for (int i = 0; i < NT; i++) begin
            w[2*i +: 2] = code_u(r % 3);
            r = r / 3;
        end
        return w;
    endfunction

    function automatic logic [W-1:0] word_b(int v);
        logic [W-1:0] w = '0;
        int r = v;
        for (int i = 0; i < NT; i++) begin
            int d = ((r % 3) + 3) % 3;
            if (d == 2) begin
                w[2*i +: 2] = code_b(-1);
                r = (r + 1) / 3;
            end else begin
                w[2*i +: 2] = code_b(d);
                r = (r - d) / 3;
            end
        end
        return w;
    endfunction

    task automatic compare(string req, logic [W+2:0] act, logic [W+2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: {err,cout,sum} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_u(int a, int b, int c, string req);
        int t;
        @(negedge clk);
        a_u = word_u(a); b_u = word_u(b); c_u = code_u(c);
        @(posedge clk); #1;
        t = a + b + c;
        compare(req, {e_u, co_u, s_u}, {1'b0, code_u(t / SPAN), word_u(t % SPAN)});
    endtask

    task automatic check_b(int a, int b, int c, string req);
        int t, co;
        @(negedge clk);
        a_b = word_b(a); b_b = word_b(b); c_b = code_b(c);
        @(posedge clk); #1;
        t  = a + b + c;
        co = (t > SPAN / 2) ? 1 : (t < -(SPAN / 2)) ? -1 : 0;
        compare(req, {e_b, co_b, s_b}, {1'b0, code_b(co), word_b(t - SPAN * co)});
    endtask

    task automatic t_reset;
        a_u = word_u(7); b_u = word_u(9); c_u = 2'b01;
        a_b = word_b(-5); b_b = word_b(3); c_b = 2'b10;
        repeat (3) @(posedge clk);
        #1;
        compare("R1", {e_u, co_u, s_u}, '0);
        compare("R1", {e_b, co_b, s_b}, '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_sweep_unsigned;
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
                for (int c = 0; c < 3; c++)
                    check_u(a, b, c, "R3");
    endtask

    task automatic t_sweep_balanced;
        for (int a = -1; a < 2; a++)
            for (int b = -1; b < 2; b++)
                for (int c = -1; c < 2; c++)
                    check_b(a, b, c, "R4");
    endtask

    task automatic t_ripple;
        check_u(80, 1, 0, "R5");
        check_u(80, 80, 2, "R5");
        check_u(40, 41, 0, "R5");
        check_u(26, 0, 1, "R5");
        check_u(53, 27, 1, "R5");
        check_b(40, 1, 0, "R5");
        check_b(-40, -1, 0, "R5");
        check_b(40, 40, 1, "R5");
        check_b(-13, -1, -1, "R5");
        check_b(-40, -40, -1, "R5");
    endtask

    task automatic t_latency;
        @(negedge clk);
        a_u = word_u(12); b_u = word_u(30); c_u = code_u(0);
        @(posedge clk); #1;
        compare("R2", {e_u, co_u, s_u}, {1'b0, 2'b00, word_u(42)});
        a_u = word_u(70); b_u = word_u(20); c_u = code_u(2);
        #3;
        compare("R2", {e_u, co_u, s_u}, {1'b0, 2'b00, word_u(42)});
        @(posedge clk); #1;
        compare("R2", {e_u, co_u, s_u}, {1'b0, code_u(1), word_u(92 - 81)});
    endtask

    task automatic t_illegal;
        // all-ones low trit forces a carry into the poisoned trit
        @(negedge clk);
        a_u = word_u(80); a_u[3:2] = 2'b11; b_u = word_u(1); c_u = 2'b00;
        a_b = word_b(40); a_b[5:4] = 2'b11; b_b = word_b(1); c_b = 2'b00;
        @(posedge clk); #1;
        compare("R6", {31'd0, e_u}, {31'd0, 1'b1});
        compare("R6", {31'd0, e_b}, {31'd0, 1'b1});
        for (int i = 0; i < NT; i++) begin
            compare("R7", {31'd0, s_u[2*i +: 2] == 2'b11}, '0);
            compare("R7", {31'd0, s_b[2*i +: 2] == 2'b11}, '0);
        end
        compare("R7", {31'd0, co_u == 2'b11 || co_b == 2'b11}, '0);
        @(negedge clk);
        a_u = word_u(2); b_u = word_u(2); c_u = 2'b11;
        a_b = word_b(1); b_b = word_b(1); c_b = 2'b11;
        @(posedge clk); #1;
        compare("R6", {31'd0, e_u & e_b}, {31'd0, 1'b1});
        compare("R7", {31'd0, co_u == 2'b11 || co_b == 2'b11}, '0);
        check_u(79, 2, 0, "R6");
        check_b(-39, -2, 1, "R6");
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_sweep_unsigned();
        t_sweep_balanced();
        t_ripple();
        t_latency();
        t_illegal();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule